// File: doc/BRIEF.md
# Differential Alert Handshake Receiver

This block is the receiving end of a differential alert link. An alert arrives on a complementary wire pair. The block answers with an acknowledge on a second complementary pair, and each alert completes a four-phase handshake: alert up, ack up, alert down, ack down. A controller can also ask the block to test the link. The block then flips the level of a third complementary pair, the ping pair, and the sender answers that toggle with the same four-phase handshake.

The block has three outputs toward the rest of the chip. The first is a one-cycle alert pulse for a genuine alert. The second is a one-cycle pulse when the handshake answering a ping has finished. The third is a signal-integrity fault level, raised whenever both alert wires carry the same value. A sender that sees bad encoding on its own inputs drives its alert wires equal and keeps toggling them, so this case also raises the fault.

A sender that has both an alert and a ping pending serves the alert first. For that reason, any handshake that begins while a ping is outstanding is counted as the answer to that ping and is not reported as an alert. The block can optionally place a two-flop synchronizer on each incoming wire for links that cross clock domains.

Top module: `diff_alert_rcv`

## Requirements
- R1: While reset is held (synchronous, active low) and on the first cycle after it is released, ack_pos_o=0, ack_neg_o=1, ping_pos_o=0, ping_neg_o=1, and alert_o, ping_done_o and fault_o are all 0.
- R2: In the synchronous configuration the pair (1,0) on alert_pos_i/alert_neg_i means the alert is high. When the block is idle and the alert is high on a clock edge, ack_pos_o rises at that edge. It then stays high until an edge at which the alert is low (0,1), and falls at that edge.
- R3: alert_o is a single-cycle pulse. It is produced at the same edge where ack rises, and only if no ping is outstanding at that edge.
- R4: When no ping is outstanding and ping_req_i is high at an edge, both ping wires flip at that edge and a ping becomes outstanding. The ping wires are always complementary.
- R5: While a ping is outstanding, ping_req_i has no effect on the ping wires.
- R6: A handshake that begins while a ping is outstanding produces no alert_o. At the edge where its ack falls, ping_done_o pulses for one cycle and the ping stops being outstanding.
- R7: When both alert wires are equal at an edge, fault_o is 1 after that edge. ack_pos_o falls, the handshake in progress is abandoned, and no alert_o or ping_done_o is produced. fault_o returns to 0 at the first edge where the alert wires are complementary again.
- R8: ack_pos_o and ack_neg_o are always complementary.
- R9: With ASYNC_EN=1, each incoming wire passes through SYNC_STAGES flops. An alert that goes high reaches ack_pos_o after SYNC_STAGES+1 edges instead of after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| ping_req_i | input | 1 | Request to start a ping test |
| alert_pos_i | input | 1 | Alert pair, true wire |
| alert_neg_i | input | 1 | Alert pair, complement wire |
| ack_pos_o | output | 1 | Acknowledge pair, true wire |
| ack_neg_o | output | 1 | Acknowledge pair, complement wire |
| ping_pos_o | output | 1 | Ping pair, true wire |
| ping_neg_o | output | 1 | Ping pair, complement wire |
| alert_o | output | 1 | One-cycle pulse for a received alert |
| ping_done_o | output | 1 | One-cycle pulse when the handshake answering a ping ends |
| fault_o | output | 1 | Signal-integrity fault on the alert pair |

## Verification
All outputs come from flops. A wrong handshake state therefore shows up one edge after the alert wires move, in one of three ways: an ack that does not follow the alert level, a lost or duplicated alert or ping-done pulse, or an ack still raised during a fault. A corrupted ping-outstanding flag shows up at the next ping request, when the ping wires either toggle when they should not or stay still when they should toggle. It also shows up as an alert pulse where a ping completion was expected.

// File: rtl/dalr_pkg.sv
// Shared types for the differential alert receiver.
// Assumes: single clock domain after the optional input synchronizers.
package dalr_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } hs_state_e;
endpackage

// File: rtl/dalr_pair_decode.sv
// Turns one incoming complementary pair into a level and an integrity flag.
// Optionally runs each wire through SYNC_STAGES flops first.
// Assumes: in async mode the skew between the wires is below one clock period.
module dalr_pair_decode #(
    parameter bit          ASYNC_EN    = 1'b0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pos_i,
    input  logic neg_i,
    output logic level_o,
    output logic bad_o
);
    logic pos_s, neg_s;

    if (ASYNC_EN) begin : g_sync
        logic [SYNC_STAGES-1:0] pos_q, neg_q;
        // Synchronizer chain for both wires; idle value is (0,1).
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                pos_q <= '0;
                neg_q <= '1;
            end else begin
                pos_q <= {pos_q[SYNC_STAGES-2:0], pos_i};
                neg_q <= {neg_q[SYNC_STAGES-2:0], neg_i};
            end
        end
        assign pos_s = pos_q[SYNC_STAGES-1];
        assign neg_s = neg_q[SYNC_STAGES-1];
    end else begin : g_direct
        assign pos_s = pos_i;
        assign neg_s = neg_i;
    end

    assign level_o = pos_s;
    assign bad_o   = ~(pos_s ^ neg_s);
endmodule

// File: rtl/dalr_ping_gen.sv
// Holds the ping-outstanding flag and drives the ping pair.
// A request toggles both wires only when no ping is outstanding.
// Assumes: clr_i is a single-cycle strobe from the handshake engine.
module dalr_ping_gen (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic clr_i,
    output logic pend_o,
    output logic pos_o,
    output logic neg_o
);
    logic fire;
    assign fire = req_i & ~pend_o;

    // Ping level flops and outstanding flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_o <= 1'b0;
            pos_o  <= 1'b0;
            neg_o  <= 1'b1;
        end else begin
            if (fire) begin
                pos_o <= ~pos_o;
                neg_o <= ~neg_o;
            end
            if (fire)       pend_o <= 1'b1;
            else if (clr_i) pend_o <= 1'b0;
        end
    end
endmodule

// File: rtl/dalr_hs_fsm.sv
// Four-phase handshake engine. It raises ack on a high alert and drops it
// once the alert falls, tags each handshake as alert or ping answer, and
// abandons a handshake on an integrity fault.
// Assumes: level_i/bad_i are already in the local clock domain.
module dalr_hs_fsm
    import dalr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    input  logic bad_i,
    input  logic ping_pend_i,
    output logic ping_clr_o,
    output logic ack_pos_o,
    output logic ack_neg_o,
    output logic alert_o,
    output logic ping_done_o,
    output logic fault_o
);
    hs_state_e state_q, state_d;
    logic      tag_ping_q, tag_ping_d;
    logic      start, finish;

    // Next-state decision for the handshake.
    always_comb begin
        state_d    = state_q;
        tag_ping_d = tag_ping_q;
        start      = 1'b0;
        finish     = 1'b0;
        if (bad_i) begin
            state_d    = ST_IDLE;
            tag_ping_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (level_i) begin
                    state_d    = ST_HOLD;
                    tag_ping_d = ping_pend_i;
                    start      = 1'b1;
                end
                ST_HOLD: if (!level_i) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign ping_clr_o = finish & tag_ping_q;

    // State and registered outputs.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q     <= ST_IDLE;
            tag_ping_q  <= 1'b0;
            ack_pos_o   <= 1'b0;
            ack_neg_o   <= 1'b1;
            alert_o     <= 1'b0;
            ping_done_o <= 1'b0;
            fault_o     <= 1'b0;
        end else begin
            state_q     <= state_d;
            tag_ping_q  <= tag_ping_d;
            ack_pos_o   <= (state_d == ST_HOLD);
            ack_neg_o   <= (state_d != ST_HOLD);
            alert_o     <= start & ~ping_pend_i;
            ping_done_o <= finish & tag_ping_q;
            fault_o     <= bad_i;
        end
    end
endmodule

// File: rtl/diff_alert_rcv.sv
// Top of the differential alert receiver: alert pair decode, handshake
// engine and ping generator.
// Assumes: the sender waits for ack before dropping alert (four-phase).
module diff_alert_rcv #(
    parameter bit          ASYNC_EN    = 1'b0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ping_req_i,
    input  logic alert_pos_i,
    input  logic alert_neg_i,
    output logic ack_pos_o,
    output logic ack_neg_o,
    output logic ping_pos_o,
    output logic ping_neg_o,
    output logic alert_o,
    output logic ping_done_o,
    output logic fault_o
);
    logic lvl, bad, pend, pclr;

    dalr_pair_decode #(
        .ASYNC_EN   (ASYNC_EN),
        .SYNC_STAGES(SYNC_STAGES)
    ) dec_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pos_i  (alert_pos_i),
        .neg_i  (alert_neg_i),
        .level_o(lvl),
        .bad_o  (bad)
    );

    dalr_hs_fsm fsm_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .level_i    (lvl),
        .bad_i      (bad),
        .ping_pend_i(pend),
        .ping_clr_o (pclr),
        .ack_pos_o  (ack_pos_o),
        .ack_neg_o  (ack_neg_o),
        .alert_o    (alert_o),
        .ping_done_o(ping_done_o),
        .fault_o    (fault_o)
    );

    dalr_ping_gen ping_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .req_i (ping_req_i),
        .clr_i (pclr),
        .pend_o(pend),
        .pos_o (ping_pos_o),
        .neg_o (ping_neg_o)
    );
endmodule

// File: rtl/diff_alert_rcv_chk.sv
// Port-level property checker for diff_alert_rcv, attached by bind.
module diff_alert_rcv_chk #(
    parameter bit ASYNC_EN = 1'b0
) (
    input logic clk_i,
    input logic rst_ni,
    input logic ping_req_i,
    input logic alert_pos_i,
    input logic alert_neg_i,
    input logic ack_pos_o,
    input logic ack_neg_o,
    input logic ping_pos_o,
    input logic ping_neg_o,
    input logic alert_o,
    input logic ping_done_o,
    input logic fault_o
);
    // R8
    ack_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_pos_o != ack_neg_o);
    // R4
    ping_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ping_pos_o != ping_neg_o);
    // R3
    alert_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alert_o |=> !alert_o);
    // R6
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ping_done_o |=> !ping_done_o);
    // R7
    fault_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> !ack_pos_o && !alert_o && !ping_done_o);
    // R5
    ping_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ping_pos_o) |-> $past(ping_req_i));
    if (!ASYNC_EN) begin : g_sync_chk
        // R2
        ack_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(ack_pos_o) |-> $past(alert_pos_i && !alert_neg_i));
    end
endmodule

bind diff_alert_rcv diff_alert_rcv_chk #(.ASYNC_EN(ASYNC_EN)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ping_req_i (ping_req_i),
    .alert_pos_i(alert_pos_i),
    .alert_neg_i(alert_neg_i),
    .ack_pos_o  (ack_pos_o),
    .ack_neg_o  (ack_neg_o),
    .ping_pos_o (ping_pos_o),
    .ping_neg_o (ping_neg_o),
    .alert_o    (alert_o),
    .ping_done_o(ping_done_o),
    .fault_o    (fault_o)
);

// File: tb/diff_alert_rcv_tb_top.sv
// Self-checking bench: a per-cycle vector table, then directed tests.
module diff_alert_rcv_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic ap = 1'b0;
    logic an = 1'b1;
    logic ack_p, ack_n, ping_p, ping_n, alrt, done, flt;
    logic a_ack_p, a_ack_n, a_ping_p, a_ping_n, a_alrt, a_done, a_flt;
    int   n_run = 0;
    int   n_fail = 0;

    always #10 clk = ~clk;

    diff_alert_rcv dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ping_req_i(req),
        .alert_pos_i(ap), .alert_neg_i(an),
        .ack_pos_o(ack_p), .ack_neg_o(ack_n),
        .ping_pos_o(ping_p), .ping_neg_o(ping_n),
        .alert_o(alrt), .ping_done_o(done), .fault_o(flt)
    );

    diff_alert_rcv #(.ASYNC_EN(1'b1), .SYNC_STAGES(2)) dut_async_i (
        .clk_i(clk), .rst_ni(rst_n), .ping_req_i(1'b0),
        .alert_pos_i(ap), .alert_neg_i(an),
        .ack_pos_o(a_ack_p), .ack_neg_o(a_ack_n),
        .ping_pos_o(a_ping_p), .ping_neg_o(a_ping_n),
        .alert_o(a_alrt), .ping_done_o(a_done), .fault_o(a_flt)
    );

    // Vector fields: [7]alert_pos [6]alert_neg [5]ping_req |
    // expected [4]ack_pos [3]alert_o [2]ping_done [1]fault [0]ping_pos
    localparam int NV = 17;
    localparam logic [7:0] VEC [NV] = '{
        8'b010_00000, // idle
        8'b100_11000, // R2 R3 alert rises
        8'b100_10000, // R2 hold
        8'b010_00000, // R2 ack drops, no ping tag
        8'b011_00001, // R4 ping toggles
        8'b010_00001, // quiet
        8'b101_10001, // R5 R6 req ignored, no alert pulse
        8'b010_00101, // R6 ping done
        8'b011_00000, // R4 toggles back
        8'b000_00010, // R7 fault (0,0)
        8'b110_00010, // R7 fault (1,1)
        8'b010_00000, // R7 fault clears
        8'b100_10000, // R6 handshake answers ping
        8'b010_00100, // R6 ping done
        8'b100_11000, // R3 genuine alert again
        8'b110_00010, // R7 fault aborts handshake
        8'b010_00000  // R7 recovered
    };

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic pairs(input string tag);
        check({tag, " R8 ack pair"}, {4'b0, ack_p ^ ack_n}, 5'b1);
        check({tag, " R4 ping pair"}, {4'b0, ping_p ^ ping_n}, 5'b1);
    endtask

    initial begin : watchdog
        #2000000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 in reset", {ack_p, alrt, done, flt, ping_p}, 5'b0);
        pairs("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {ack_p, alrt, done, flt, ping_p}, 5'b0);
        check("R1 ping_neg", {4'b0, ping_n}, 5'b1);

        for (int k = 0; k < NV; k++) begin
            ap  = VEC[k][7];
            an  = VEC[k][6];
            req = VEC[k][5];
            @(negedge clk);
            check($sformatf("vec%0d R2 R3 R6 R7 R4", k),
                  {ack_p, alrt, done, flt, ping_p}, VEC[k][4:0]);
            pairs($sformatf("vec%0d", k));
        end

        // R5: request held high for many cycles toggles only once
        req = 1'b1;
        ap = 1'b0; an = 1'b1;
        @(negedge clk);
        check("R4 held req toggles", {4'b0, ping_p}, 5'b1);
        repeat (4) @(negedge clk);
        check("R5 held req ignored", {4'b0, ping_p}, 5'b1);
        req = 1'b0;

        // R9: async variant needs SYNC_STAGES+1 edges
        repeat (6) @(negedge clk);
        ap = 1'b1; an = 1'b0;
        @(negedge clk);
        check("R9 async edge1", {4'b0, a_ack_p}, 5'b0);
        @(negedge clk);
        check("R9 async edge2", {4'b0, a_ack_p}, 5'b0);
        @(negedge clk);
        check("R9 async edge3", {4'b0, a_ack_p}, 5'b1);
        check("R6 handshake tagged as ping", {4'b0, alrt}, 5'b0);
        ap = 1'b0; an = 1'b1;
        @(negedge clk);
        check("R6 ping done held req", {4'b0, done}, 5'b1);

        // R1: reset in the middle of a handshake
        ap = 1'b1; an = 1'b0;
        @(negedge clk);
        check("R2 ack before reset", {4'b0, ack_p}, 5'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid handshake", {ack_p, alrt, done, flt, ping_p}, 5'b0);
        pairs("R1 mid");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule